// File: doc/BRIEF.md
# SIMD Single-Structure Load Decoder

This block turns a 32-bit SIMD single-structure load instruction word into the control values that a load pipeline needs. It pulls out the register and control fields and works out several values from them: the effective element scale, the number of structure elements, the lane that the load writes, whether the loaded element is copied to every lane, the vector and element sizes, whether the base register is written back, whether the access is tag-checked, and whether the encoding is undefined. It also lists the consecutive target registers that the structure fills, wrapping modulo 32, with a mask of the entries that are in use.

The decoder is purely combinational and holds no state. A control module sorts the encoding into a lane kind and makes the legality decision. It hands these to a datapath module as a small strobe struct, and the datapath builds the index, size and register-list outputs.

Top module: `simdLdStructDec`

## Requirements
- R1: Field positions: tgtReg = bits 4:0, baseReg = bits 9:5, sizeFld = bits 11:10, sBit = bit 12, opcode = bits 15:13, rBit = bit 21, lBit = bit 22, qBit = bit 30. The raw scale is opcode[2:1].
- R2: elemCount = {opcode[0], rBit} + 1, with a range of 1 to 4. regList entry k (bits 5k+4:5k) equals (tgtReg + k) mod 32 for k = 0..3. regMask bit k is 1 exactly when k < elemCount.
- R3: Raw scale 2'b11 means load-and-replicate. It is undefined when lBit is 0 or sBit is 1. Otherwise replicate is 1. In this case effScale = sizeFld and laneIdx = 0.
- R4: Raw scale 2'b00 (byte) gives laneIdx = {qBit, sBit, sizeFld} and effScale = 2'b00. It is never undefined.
- R5: Raw scale 2'b01 (halfword) is undefined when sizeFld[0] is 1. Otherwise laneIdx = {qBit, sBit, sizeFld[1]}. effScale = 2'b01.
- R6: Raw scale 2'b10 with sizeFld[0] = 0 is a word: undefined when sizeFld[1] is 1, laneIdx = {qBit, sBit}, effScale = 2'b10. With sizeFld[0] = 1 it is a doubleword: undefined when sizeFld[1] or sBit is 1, laneIdx = qBit, effScale = 2'b11.
- R7: dataSize = 64 << qBit, elemSize = 8 << effScale and elemBytes = 1 << effScale.
- R8: Bit 23 selects the post-index form. In that form offReg = bits 20:16, and writeBack = 1 unless the encoding is undefined. In the no-offset form offReg = 0 and writeBack = 0.
- R9: tagCheck = 1 when bit 23 is set or baseReg is not 31. The undefined flag does not affect it.
- R10: When undef is 1, replicate = 0, writeBack = 0 and laneIdx = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to decode |
| tgtReg | output | 5 | First target vector register |
| baseReg | output | 5 | Base address register |
| offReg | output | 5 | Post-index offset register, 0 in no-offset form |
| qBit | output | 1 | Full-width vector select |
| lBit | output | 1 | Load flag field |
| rBit | output | 1 | Element count low bit field |
| sBit | output | 1 | Lane index field bit |
| opcode | output | 3 | Opcode field |
| sizeFld | output | 2 | Size field |
| effScale | output | 2 | Effective element scale |
| elemCount | output | 3 | Structure element count, 1 to 4 |
| laneIdx | output | 4 | Lane written by the load |
| replicate | output | 1 | Copy the element to all lanes |
| dataSize | output | 8 | Vector size in bits, 64 or 128 |
| elemSize | output | 7 | Element size in bits |
| elemBytes | output | 4 | Element size in bytes |
| writeBack | output | 1 | Base register update |
| tagCheck | output | 1 | Access is tag-checked |
| undef | output | 1 | Undefined encoding |
| regList | output | 20 | Four consecutive target registers, entry k at bits 5k+4:5k |
| regMask | output | 4 | Register list entries in use |

## Verification
The block holds no state, so a wrong strobe from the control module shows at the ports in the same evaluation as the instruction word that caused it. A misclassified lane kind appears as a wrong laneIdx or effScale. A missed legality rule appears as undef disagreeing with the expected value while replicate or writeBack is still high. Sweeping every combination of the control fields drives each legality branch into both its defined and undefined outcomes. Directed words cover register wraparound at 31 and the tag-check rule around base register 31.

// File: rtl/simdLdStructDec_pkg.sv
`timescale 1ns/1ps
package simdLdStructDec_pkg;
  localparam int INSN_W   = 32;
  localparam int REG_W    = 5;
  localparam int RT_LSB   = 0;
  localparam int RN_LSB   = 5;
  localparam int SIZE_LSB = 10;
  localparam int S_POS    = 12;
  localparam int OPC_LSB  = 13;
  localparam int RM_LSB   = 16;
  localparam int R_POS    = 21;
  localparam int L_POS    = 22;
  localparam int FORM_POS = 23;
  localparam int Q_POS    = 30;
  localparam int MAX_ELEMS = 4;
  localparam int CNT_W    = $clog2(MAX_ELEMS + 1);
  localparam int LANE_W   = 4;
  localparam int DSIZE_W  = 8;
  localparam int ESIZE_W  = 7;
  localparam int EBYTES_W = 4;

  typedef enum logic [2:0] {
    LANE_BYTE  = 3'd0,
    LANE_HALF  = 3'd1,
    LANE_WORD  = 3'd2,
    LANE_DWORD = 3'd3,
    LANE_NONE  = 3'd4
  } laneKind_e;

  typedef struct packed {
    logic       replicate;
    logic       undef;
    logic       writeBack;
    logic [1:0] effScale;
    laneKind_e  laneKind;
  } ctrlStrb_t;
endpackage

// File: rtl/simdLdStructDec_ctrl.sv
`timescale 1ns/1ps
module simdLdStructDec_ctrl
  import simdLdStructDec_pkg::*;
(
  input  logic [1:0] rawScale,
  input  logic [1:0] sizeFld,
  input  logic       lBit,
  input  logic       sBit,
  input  logic       formBit,
  output ctrlStrb_t  strb
);
  logic       repNow;
  logic       undefNow;
  logic [1:0] scaleNow;
  laneKind_e  kindNow;

  always_comb begin
    repNow   = 1'b0;
    undefNow = 1'b0;
    scaleNow = rawScale;
    kindNow  = LANE_NONE;
    unique case (rawScale)
      2'b00: kindNow = LANE_BYTE;
      2'b01: begin
        kindNow  = LANE_HALF;
        undefNow = sizeFld[0];
      end
      2'b10: begin
        if (sizeFld[0]) begin
          kindNow  = LANE_DWORD;
          scaleNow = 2'b11;
          undefNow = sizeFld[1] | sBit;
        end else begin
          kindNow  = LANE_WORD;
          undefNow = sizeFld[1];
        end
      end
      default: begin
        kindNow  = LANE_NONE;
        scaleNow = sizeFld;
        if (!lBit || sBit) undefNow = 1'b1;
        else repNow = 1'b1;
      end
    endcase
  end

  always_comb begin
    strb.replicate = repNow & ~undefNow;
    strb.undef     = undefNow;
    strb.writeBack = formBit & ~undefNow;
    strb.effScale  = scaleNow;
    strb.laneKind  = kindNow;
  end
endmodule

// File: rtl/simdLdStructDec_dp.sv
`timescale 1ns/1ps
module simdLdStructDec_dp
  import simdLdStructDec_pkg::*;
#(
  parameter int NUM_ELEMS = MAX_ELEMS,
  parameter int RW        = REG_W
) (
  input  ctrlStrb_t              strb,
  input  logic [RW-1:0]          tgtReg,
  input  logic [RW-1:0]          baseReg,
  input  logic [RW-1:0]          rawOffReg,
  input  logic                   formBit,
  input  logic                   qBit,
  input  logic                   sBit,
  input  logic                   rBit,
  input  logic                   opcLow,
  input  logic [1:0]             sizeFld,
  output logic [RW-1:0]          offReg,
  output logic [CNT_W-1:0]       elemCount,
  output logic [LANE_W-1:0]      laneIdx,
  output logic [DSIZE_W-1:0]     dataSize,
  output logic [ESIZE_W-1:0]     elemSize,
  output logic [EBYTES_W-1:0]    elemBytes,
  output logic                   tagCheck,
  output logic [NUM_ELEMS*RW-1:0] regList,
  output logic [NUM_ELEMS-1:0]   regMask
);
  localparam logic [RW-1:0] LAST_REG = {RW{1'b1}};

  always_comb begin
    if (strb.undef) begin
      laneIdx = '0;
    end else begin
      unique case (strb.laneKind)
        LANE_BYTE:  laneIdx = {qBit, sBit, sizeFld};
        LANE_HALF:  laneIdx = {1'b0, qBit, sBit, sizeFld[1]};
        LANE_WORD:  laneIdx = {2'b00, qBit, sBit};
        LANE_DWORD: laneIdx = {3'b000, qBit};
        default:    laneIdx = '0;
      endcase
    end
  end

  assign elemCount = CNT_W'({opcLow, rBit}) + CNT_W'(1);
  assign dataSize  = DSIZE_W'(64) << qBit;
  assign elemSize  = ESIZE_W'(8) << strb.effScale;
  assign elemBytes = EBYTES_W'(1) << strb.effScale;
  assign tagCheck  = formBit | (baseReg != LAST_REG);
  assign offReg    = formBit ? rawOffReg : '0;

  for (genvar k = 0; k < NUM_ELEMS; k++) begin : g_regs
    assign regList[k*RW +: RW] = tgtReg + RW'(k);
    assign regMask[k]          = (CNT_W'(k) < elemCount);
  end
endmodule

// File: rtl/simdLdStructDec.sv
`timescale 1ns/1ps
module simdLdStructDec
  import simdLdStructDec_pkg::*;
(
  input  logic [INSN_W-1:0]          instrWord,
  output logic [REG_W-1:0]           tgtReg,
  output logic [REG_W-1:0]           baseReg,
  output logic [REG_W-1:0]           offReg,
  output logic                       qBit,
  output logic                       lBit,
  output logic                       rBit,
  output logic                       sBit,
  output logic [2:0]                 opcode,
  output logic [1:0]                 sizeFld,
  output logic [1:0]                 effScale,
  output logic [CNT_W-1:0]           elemCount,
  output logic [LANE_W-1:0]          laneIdx,
  output logic                       replicate,
  output logic [DSIZE_W-1:0]         dataSize,
  output logic [ESIZE_W-1:0]         elemSize,
  output logic [EBYTES_W-1:0]        elemBytes,
  output logic                       writeBack,
  output logic                       tagCheck,
  output logic                       undef,
  output logic [MAX_ELEMS*REG_W-1:0] regList,
  output logic [MAX_ELEMS-1:0]       regMask
);
  ctrlStrb_t strb;
  logic      formBit;
  logic      unusedFixedBits;

  assign tgtReg  = instrWord[RT_LSB +: REG_W];
  assign baseReg = instrWord[RN_LSB +: REG_W];
  assign sizeFld = instrWord[SIZE_LSB +: 2];
  assign sBit    = instrWord[S_POS];
  assign opcode  = instrWord[OPC_LSB +: 3];
  assign rBit    = instrWord[R_POS];
  assign lBit    = instrWord[L_POS];
  assign formBit = instrWord[FORM_POS];
  assign qBit    = instrWord[Q_POS];
  assign unusedFixedBits = ^{instrWord[31], instrWord[29:24]};

  simdLdStructDec_ctrl u_ctrl (
    .rawScale (opcode[2:1]),
    .sizeFld  (sizeFld),
    .lBit     (lBit),
    .sBit     (sBit),
    .formBit  (formBit),
    .strb     (strb)
  );

  simdLdStructDec_dp #(.NUM_ELEMS(MAX_ELEMS), .RW(REG_W)) u_dp (
    .strb      (strb),
    .tgtReg    (tgtReg),
    .baseReg   (baseReg),
    .rawOffReg (instrWord[RM_LSB +: REG_W]),
    .formBit   (formBit),
    .qBit      (qBit),
    .sBit      (sBit),
    .rBit      (rBit),
    .opcLow    (opcode[0]),
    .sizeFld   (sizeFld),
    .offReg    (offReg),
    .elemCount (elemCount),
    .laneIdx   (laneIdx),
    .dataSize  (dataSize),
    .elemSize  (elemSize),
    .elemBytes (elemBytes),
    .tagCheck  (tagCheck),
    .regList   (regList),
    .regMask   (regMask)
  );

  assign effScale  = strb.effScale;
  assign replicate = strb.replicate;
  assign writeBack = strb.writeBack;
  assign undef     = strb.undef;
endmodule

// File: rtl/simdLdStructDec_chk.sv
`timescale 1ns/1ps
module simdLdStructDec_chk (
  input logic [2:0] opcode,
  input logic [1:0] sizeFld,
  input logic [1:0] effScale,
  input logic [2:0] elemCount,
  input logic [3:0] laneIdx,
  input logic       replicate,
  input logic [6:0] elemSize,
  input logic [3:0] elemBytes,
  input logic       writeBack,
  input logic       tagCheck,
  input logic       undef,
  input logic [3:0] regMask
);
  always_comb begin
    // R10: an undefined encoding never replicates, writes back or selects a lane
    a_r10_undef_quiet: assert (!undef || (!replicate && !writeBack && laneIdx == 4'd0));
    // R2: the mask population equals the element count, which stays in 1..4
    a_r2_mask_count: assert ($countones(regMask) == int'(elemCount) && elemCount != 3'd0);
    // R7: byte count and bit size agree
    a_r7_bytes_bits: assert ({elemBytes, 3'b000} == elemSize);
    // R9: writeback always implies tag checking
    a_r9_tag_on_wb: assert (!writeBack || tagCheck);
    // R3: replication takes the size field as scale and lane zero
    a_r3_rep_scale: assert (!replicate || (effScale == sizeFld && laneIdx == 4'd0 && opcode[2:1] == 2'b11));
    // R6: a defined doubleword lane is 0 or 1
    a_r6_dword_lane: assert (!(opcode[2:1] == 2'b10 && sizeFld[0] && !undef) || (laneIdx <= 4'd1 && effScale == 2'b11));
  end
endmodule

bind simdLdStructDec simdLdStructDec_chk u_chk (
  .opcode    (opcode),
  .sizeFld   (sizeFld),
  .effScale  (effScale),
  .elemCount (elemCount),
  .laneIdx   (laneIdx),
  .replicate (replicate),
  .elemSize  (elemSize),
  .elemBytes (elemBytes),
  .writeBack (writeBack),
  .tagCheck  (tagCheck),
  .undef     (undef),
  .regMask   (regMask)
);

// File: tb/sim_simdLdStructDec.sv
`timescale 1ns/1ps
module sim_simdLdStructDec;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instrWord = 32'd0;
  logic [4:0]  tgtReg, baseReg, offReg;
  logic        qBit, lBit, rBit, sBit;
  logic [2:0]  opcode;
  logic [1:0]  sizeFld, effScale;
  logic [2:0]  elemCount;
  logic [3:0]  laneIdx;
  logic        replicate;
  logic [7:0]  dataSize;
  logic [6:0]  elemSize;
  logic [3:0]  elemBytes;
  logic        writeBack, tagCheck, undef;
  logic [19:0] regList;
  logic [3:0]  regMask;

  simdLdStructDec u0 (
    .instrWord(instrWord), .tgtReg(tgtReg), .baseReg(baseReg), .offReg(offReg),
    .qBit(qBit), .lBit(lBit), .rBit(rBit), .sBit(sBit), .opcode(opcode),
    .sizeFld(sizeFld), .effScale(effScale), .elemCount(elemCount), .laneIdx(laneIdx),
    .replicate(replicate), .dataSize(dataSize), .elemSize(elemSize),
    .elemBytes(elemBytes), .writeBack(writeBack), .tagCheck(tagCheck),
    .undef(undef), .regList(regList), .regMask(regMask)
  );

  int checkCount = 0;
  int errorCount = 0;
  bit finished = 1'b0;

  // expected values
  logic [1:0] xScale;
  logic [3:0] xLane;
  logic       xRep, xUndef, xWb, xTag;
  int         xCount;

  task automatic checkVal(input string req, input string nm, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      errorCount++;
      $display("FAIL %s %s: actual %0d expected %0d (instr %h)", req, nm, act, exp, instrWord);
    end
  endtask

  function automatic logic [31:0] mkWord(input bit q, input bit post, input bit l, input bit r,
      input logic [2:0] opc, input bit s, input logic [1:0] sz,
      input logic [4:0] rn, input logic [4:0] rt, input logic [4:0] rm);
    logic [31:0] w;
    w = 32'h0D00_0000;
    w[30] = q; w[23] = post; w[22] = l; w[21] = r;
    w[20:16] = post ? rm : 5'd0;
    w[15:13] = opc; w[12] = s; w[11:10] = sz; w[9:5] = rn; w[4:0] = rt;
    return w;
  endfunction

  // expectation built from the requirement text
  task automatic computeExpected(input logic [31:0] w);
    logic [1:0] sc, sz;
    logic q, s, l;
    sc = w[15:14]; sz = w[11:10]; q = w[30]; s = w[12]; l = w[22];
    xRep = 1'b0; xUndef = 1'b0; xLane = 4'd0; xScale = sc;
    if (sc == 2'b11) begin
      xScale = sz;
      if (l == 1'b0 || s == 1'b1) xUndef = 1'b1; else xRep = 1'b1;
    end else if (sc == 2'b00) begin
      xLane = {q, s, sz};
    end else if (sc == 2'b01) begin
      xUndef = sz[0];
      xLane = {1'b0, q, s, sz[1]};
    end else if (sz[0] == 1'b0) begin
      xUndef = sz[1];
      xLane = {2'b00, q, s};
    end else begin
      xScale = 2'b11;
      xUndef = sz[1] || s;
      xLane = {3'b000, q};
    end
    if (xUndef) xLane = 4'd0;
    xWb = w[23] && !xUndef;
    xTag = w[23] || (w[9:5] != 5'd31);
    xCount = int'({w[13], w[21]}) + 1;
  endtask

  task automatic applyWord(input logic [31:0] w);
    @(posedge clk);
    instrWord = w;
    #5;
  endtask

  task automatic checkAll();
    computeExpected(instrWord);
    checkVal("R1", "tgtReg", int'(tgtReg), int'(instrWord[4:0]));
    checkVal("R1", "baseReg", int'(baseReg), int'(instrWord[9:5]));
    checkVal("R1", "fields", int'({qBit, lBit, rBit, sBit, opcode, sizeFld}),
             int'({instrWord[30], instrWord[22], instrWord[21], instrWord[12], instrWord[15:13], instrWord[11:10]}));
    checkVal("R2", "elemCount", int'(elemCount), xCount);
    for (int k = 0; k < 4; k++) begin
      checkVal("R2", "regList", int'(regList[k*5 +: 5]), (int'(instrWord[4:0]) + k) % 32);
      checkVal("R2", "regMask", int'(regMask[k]), (k < xCount) ? 1 : 0);
    end
    checkVal("R3", "replicate", int'(replicate), int'(xRep));
    checkVal("R4", "effScale", int'(effScale), int'(xScale));
    checkVal("R5", "laneIdx", int'(laneIdx), int'(xLane));
    checkVal("R6", "undef", int'(undef), int'(xUndef));
    checkVal("R7", "dataSize", int'(dataSize), instrWord[30] ? 128 : 64);
    checkVal("R7", "elemSize", int'(elemSize), 8 << xScale);
    checkVal("R7", "elemBytes", int'(elemBytes), 1 << xScale);
    checkVal("R8", "writeBack", int'(writeBack), int'(xWb));
    checkVal("R8", "offReg", int'(offReg), instrWord[23] ? int'(instrWord[20:16]) : 0);
    checkVal("R9", "tagCheck", int'(tagCheck), int'(xTag));
  endtask

  task automatic testIdle();
    // all-zero word: byte lane 0, one element, 64-bit vector, tag checked (base 0)
    #5;
    checkVal("R4", "idle laneIdx", int'(laneIdx), 0);
    checkVal("R2", "idle regMask", int'(regMask), 1);
    checkVal("R7", "idle dataSize", int'(dataSize), 64);
    checkVal("R9", "idle tagCheck", int'(tagCheck), 1);
    checkVal("R10", "idle undef", int'(undef), 0);
  endtask

  task automatic testWrap();
    applyWord(mkWord(1, 0, 1, 1, 3'b111, 0, 2'b10, 5'd3, 5'd30, 5'd0));
    checkVal("R2", "wrap list", int'(regList), int'({5'd1, 5'd0, 5'd31, 5'd30}));
    checkVal("R3", "wrap replicate", int'(replicate), 1);
    checkVal("R3", "wrap effScale", int'(effScale), 2);
    checkAll();
  endtask

  task automatic testTagBase();
    applyWord(mkWord(0, 0, 1, 0, 3'b000, 0, 2'b00, 5'd31, 5'd4, 5'd0));
    checkVal("R9", "no-offset sp tagCheck", int'(tagCheck), 0);
    applyWord(mkWord(0, 1, 1, 0, 3'b000, 0, 2'b00, 5'd31, 5'd4, 5'd9));
    checkVal("R9", "post sp tagCheck", int'(tagCheck), 1);
    checkVal("R8", "post offReg", int'(offReg), 9);
    checkVal("R8", "post writeBack", int'(writeBack), 1);
  endtask

  task automatic testUndefQuiet();
    applyWord(mkWord(1, 1, 0, 0, 3'b110, 0, 2'b01, 5'd2, 5'd7, 5'd5));
    checkVal("R10", "rep L0 undef", int'(undef), 1);
    checkVal("R10", "rep L0 replicate", int'(replicate), 0);
    checkVal("R10", "rep L0 writeBack", int'(writeBack), 0);
    applyWord(mkWord(1, 1, 1, 0, 3'b100, 1, 2'b01, 5'd2, 5'd7, 5'd5));
    checkVal("R6", "dword S undef", int'(undef), 1);
    checkVal("R10", "dword S laneIdx", int'(laneIdx), 0);
    checkVal("R10", "dword S writeBack", int'(writeBack), 0);
    applyWord(mkWord(1, 0, 1, 0, 3'b100, 0, 2'b01, 5'd2, 5'd7, 5'd0));
    checkVal("R6", "dword lane", int'(laneIdx), 1);
    checkVal("R6", "dword effScale", int'(effScale), 3);
  endtask

  task automatic testSweep();
    int n = 0;
    for (int q = 0; q < 2; q++)
      for (int p = 0; p < 2; p++)
        for (int l = 0; l < 2; l++)
          for (int r = 0; r < 2; r++)
            for (int o = 0; o < 8; o++)
              for (int s = 0; s < 2; s++)
                for (int z = 0; z < 4; z++) begin
                  applyWord(mkWord(q[0], p[0], l[0], r[0], o[2:0], s[0], z[1:0],
                                   ((n % 5) == 0) ? 5'd31 : 5'(n * 7),
                                   5'(n * 3 + 28), 5'(n * 11)));
                  checkAll();
                  n++;
                end
  endtask

  initial begin
    testIdle();
    testWrap();
    testTagBase();
    testUndefQuiet();
    testSweep();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checkCount, errorCount);
    $finish;
  end

  initial begin
    #(150000 * 20);
    if (!finished) begin
      checkCount++;
      errorCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checkCount, errorCount);
      $finish;
    end
  end
endmodule